// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Unit

This unit is the register front end of a descriptor-driven DMA controller. It sits on a 32-bit memory-mapped slave bus and serves several channels. Each channel has its own 8 KiB address window. A channel holds its pointer registers, its configuration, a command register and a stream-command register. It also tracks a three-valued channel state and an end-of-list flag, and it combines raw interrupt causes with a mask to drive one level interrupt line.

The unit does not move any data. It turns register writes into one-cycle request strobes toward the data engine: load a data descriptor, load a context descriptor, and start. It receives descriptor responses, interrupt causes and end-of-list notices back from the engine. A write to the command register runs a short continue sequence. The sequence re-reads the current descriptor and, if software has cleared its end-of-list bit, follows the next pointer and restarts the channel.

Top module: `dmach_regif`

## Requirements
- R1: The channel index is `addr_i[ADDR_W-1:13]` and the register index is `addr_i[7:2]`. The registers sit at these byte offsets inside the window:
  - current descriptor at 0x00
  - saved data pointer at 0x58
  - saved buffer position at 0x5C
  - group at 0x60
  - group-down at 0x7C
  - command at 0x80
  - config at 0x84
  - status at 0x88
  - mask at 0x8C
  - acknowledge at 0x90
  - raw causes at 0x94
  - masked causes at 0x98
  - stream command at 0x9C

  The pointer registers, command, config and stream command read back what was last written. Any other offset reads 0 and ignores writes. Read data appears on `rdata_o` in the cycle after the access.
- R2: After reset every register reads 0 except status, which reads 0x101. `irq_o` is low and no strobe is active.
- R3: Status is read-only and holds the state in bits [2:0] (reset = 1, stopped = 2, running = 4), the end-of-list flag in bit 5 and the constant 1 in bits [9:8]. A config write with bit 0 = 0 sets the state to reset. Otherwise, bit 1 = 1 sets the state to stopped. Otherwise the state is unchanged.
- R4: A cause bit of `cause_i` sets the matching raw bit, which stays set. Masked causes read raw AND mask. `irq_o` of a channel is high exactly when its masked causes are nonzero, and it follows a mask write from the cycle after.
- R5: A write to the acknowledge register clears every raw bit written as 1, and the register always reads 0. A cause arriving in the same cycle as the acknowledge keeps its bit set.
- R6: A stream-command write acts on its low 10 bits only. If those bits overlap 0x140, `desc_req_o` pulses in the next cycle, and the current descriptor register and `desc_addr_o` take the saved data pointer. If bit 0x20 is also set, `start_o` pulses in that same cycle, the state becomes running and the end-of-list flag clears. Bit 0x20 on its own does nothing.
- R7: A stream command whose low bits overlap 0x200 pulses `ctx_req_o` in the next cycle, with `ctx_addr_o` equal to the group-down register.
- R8: A command-register write starts the continue sequence only when all of these hold:
  - config bit 0 is 1 and config bit 1 is 0
  - the state is running
  - the end-of-list bit of the last descriptor returned on `desc_eol_i` is 1

  In every other case the write issues no strobe.
- R9: The continue sequence first requests the descriptor at the saved data pointer. If the response has end-of-list 0 while the channel's end-of-list flag is set, the saved data pointer takes `desc_next_i` and a second request goes out at that address. The response to the second request pulses `start_o`, sets the state to running and clears the flag. In any other case the sequence ends after the first response with no further strobe.
- R10: A pulse on `eol_hit_i` sets the channel's end-of-list flag (status bit 5).
- R11: An access with `be_i` other than 4'b1111 pulses `err_o` in the next cycle. Such a write changes no register, and such a read returns 0.
- R12: A command write with any of bits [31:1] set, or a stream-command write with any of bits [31:10] set, pulses `err_o` in the next cycle. The write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 4 | Byte enables; only 4'b1111 is legal |
| addr_i | input | ADDR_W | Byte address, channel window above bit 12 |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| err_o | output | 1 | Access error pulse |
| cause_i | input | NUM_CH*CAUSE_W | Raw interrupt cause pulses from the engine |
| desc_ack_i | input | NUM_CH | Descriptor response strobe |
| desc_eol_i | input | NUM_CH | End-of-list bit of the returned descriptor |
| desc_next_i | input | NUM_CH*32 | Next pointer of the returned descriptor |
| eol_hit_i | input | NUM_CH | Engine reached end of list |
| desc_req_o | output | NUM_CH | Data-descriptor fetch request |
| desc_addr_o | output | NUM_CH*32 | Address of the requested data descriptor |
| ctx_req_o | output | NUM_CH | Context-descriptor fetch request |
| ctx_addr_o | output | NUM_CH*32 | Address of the context descriptor |
| start_o | output | NUM_CH | Channel start pulse |
| irq_o | output | NUM_CH | Level interrupt per channel |

## Verification
The bench targets the priority in config writes. A design that let the stop bit win over a cleared enable would report stopped instead of reset. It checks that an acknowledge and a new cause in the same cycle keep the cause, which an acknowledge-wins design would lose. It exercises each overlap of the stream-command codes, and checks that the burst bit alone does nothing. A design that tested for an exact code match would miss loads, and one that honoured the burst bit on its own would start the channel spuriously. For the continue sequence, the bench checks each gating condition and both outcomes of the reload. A design that skipped the channel's end-of-list flag would follow the next pointer and restart when it must stay idle.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int WIN_LSB = 13;

  localparam logic [5:0] IX_CUR  = 6'd0;
  localparam logic [5:0] IX_SPTR = 6'd22;
  localparam logic [5:0] IX_SBUF = 6'd23;
  localparam logic [5:0] IX_GRP  = 6'd24;
  localparam logic [5:0] IX_GDN  = 6'd31;
  localparam logic [5:0] IX_CMD  = 6'd32;
  localparam logic [5:0] IX_CFG  = 6'd33;
  localparam logic [5:0] IX_STAT = 6'd34;
  localparam logic [5:0] IX_MASK = 6'd35;
  localparam logic [5:0] IX_ACK  = 6'd36;
  localparam logic [5:0] IX_RAW  = 6'd37;
  localparam logic [5:0] IX_MSKD = 6'd38;
  localparam logic [5:0] IX_STRM = 6'd39;

  localparam logic [9:0] SC_LOAD_D = 10'h140;
  localparam logic [9:0] SC_BURST  = 10'h020;
  localparam logic [9:0] SC_LOAD_C = 10'h200;

  localparam logic [1:0] STREAM_SRC = 2'd1;

  typedef enum logic [2:0] {
    ST_RST  = 3'd1,
    ST_STOP = 3'd2,
    ST_RUN  = 3'd4
  } ch_state_e;

  typedef enum logic [1:0] {
    CT_IDLE,
    CT_RELOAD,
    CT_FOLLOW
  } cont_e;
endpackage

// File: rtl/dmach_dec.sv
module dmach_dec
  import dmach_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1,
  parameter int ADDR_W = WIN_LSB + CH_W
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [3:0]        be_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [CH_W-1:0]   ch_o,
  output logic [5:0]        idx_o,
  output logic [NUM_CH-1:0] wr_o,
  output logic              rd_o,
  output logic              err_o
);
  logic word_ok, bad_val;
  logic unused_bits;

  assign unused_bits = ^{addr_i[WIN_LSB-1:8], addr_i[1:0], wdata_i[0]};

  assign ch_o    = addr_i[ADDR_W-1:WIN_LSB];
  assign idx_o   = addr_i[7:2];
  assign word_ok = (be_i == 4'hF);
  assign bad_val = we_i && (((idx_o == IX_CMD) && (|wdata_i[31:1])) ||
                            ((idx_o == IX_STRM) && (|wdata_i[31:10])));
  assign err_o   = req_i && (!word_ok || bad_val);
  assign rd_o    = req_i && !we_i && word_ok;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_wr
    assign wr_o[i] = req_i && we_i && word_ok && (ch_o == CH_W'(i));
  end
endmodule

// File: rtl/dmach_irq.sv
module dmach_irq #(
  parameter int CAUSE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mask_we_i,
  input  logic               ack_we_i,
  input  logic [CAUSE_W-1:0] wdata_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [CAUSE_W-1:0] raw_o,
  output logic [CAUSE_W-1:0] mask_o,
  output logic               irq_o
);
  logic [CAUSE_W-1:0] raw_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      // new causes win over a simultaneous acknowledge
      raw_q <= (ack_we_i ? (raw_q & ~wdata_i) : raw_q) | cause_i;
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = |(raw_q & mask_q);

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_we_i && (cause_i == '0)) |=> ((raw_q & $past(wdata_i)) == '0)); // R5
  AST_CAUSE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cause_i) |=> ((raw_q & $past(cause_i)) == $past(cause_i))); // R4
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q)); // R4
endmodule

// File: rtl/dmach_chan.sv
module dmach_chan
  import dmach_pkg::*;
#(
  parameter int CAUSE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [5:0]         idx_i,
  input  logic [31:0]        wdata_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               desc_ack_i,
  input  logic               desc_eol_i,
  input  logic [31:0]        desc_next_i,
  input  logic               eol_hit_i,
  output logic [31:0]        rdata_o,
  output logic               desc_req_o,
  output logic [31:0]        desc_addr_o,
  output logic               ctx_req_o,
  output logic [31:0]        ctx_addr_o,
  output logic               start_o,
  output logic               irq_o
);
  logic [31:0] cur_q, sptr_q, sbuf_q, grp_q, gdn_q, cmd_q, cfg_q, strm_q;
  ch_state_e   state_q;
  cont_e       ct_q;
  logic        eol_q, cur_eol_q;
  logic        desc_req_q, ctx_req_q, start_q;
  logic [CAUSE_W-1:0] raw_w, mask_w;

  logic wr_cmd, wr_cfg, wr_strm, ld_d, burst, ld_c, cont_ok;
  logic [9:0] strm_cmd;

  assign wr_cmd   = wr_i && (idx_i == IX_CMD);
  assign wr_cfg   = wr_i && (idx_i == IX_CFG);
  assign wr_strm  = wr_i && (idx_i == IX_STRM);
  assign strm_cmd = wdata_i[9:0];
  assign ld_d     = wr_strm && (|(strm_cmd & SC_LOAD_D));
  assign burst    = ld_d && (|(strm_cmd & SC_BURST));
  assign ld_c     = wr_strm && (|(strm_cmd & SC_LOAD_C));
  assign cont_ok  = cfg_q[0] && !cfg_q[1] && (state_q == ST_RUN) &&
                    cur_eol_q && (ct_q == CT_IDLE);

  dmach_irq #(.CAUSE_W(CAUSE_W)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mask_we_i (wr_i && (idx_i == IX_MASK)),
    .ack_we_i  (wr_i && (idx_i == IX_ACK)),
    .wdata_i   (wdata_i[CAUSE_W-1:0]),
    .cause_i   (cause_i),
    .raw_o     (raw_w),
    .mask_o    (mask_w),
    .irq_o     (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q      <= '0;
      sptr_q     <= '0;
      sbuf_q     <= '0;
      grp_q      <= '0;
      gdn_q      <= '0;
      cmd_q      <= '0;
      cfg_q      <= '0;
      strm_q     <= '0;
      state_q    <= ST_RST;
      ct_q       <= CT_IDLE;
      eol_q      <= 1'b0;
      cur_eol_q  <= 1'b0;
      desc_req_q <= 1'b0;
      ctx_req_q  <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      desc_req_q <= 1'b0;
      ctx_req_q  <= 1'b0;
      start_q    <= 1'b0;

      if (wr_i && (idx_i == IX_CUR))  cur_q  <= wdata_i;
      if (wr_i && (idx_i == IX_SPTR)) sptr_q <= wdata_i;
      if (wr_i && (idx_i == IX_SBUF)) sbuf_q <= wdata_i;
      if (wr_i && (idx_i == IX_GRP))  grp_q  <= wdata_i;
      if (wr_i && (idx_i == IX_GDN))  gdn_q  <= wdata_i;
      if (wr_cmd)  cmd_q  <= wdata_i;
      if (wr_strm) strm_q <= wdata_i;

      if (desc_ack_i) cur_eol_q <= desc_eol_i;
      if (eol_hit_i)  eol_q     <= 1'b1;

      if (ld_d) begin
        desc_req_q <= 1'b1;
        cur_q      <= sptr_q;
        if (burst) begin
          start_q <= 1'b1;
          state_q <= ST_RUN;
          eol_q   <= 1'b0;
        end
      end
      if (ld_c) ctx_req_q <= 1'b1;

      unique case (ct_q)
        CT_IDLE: begin
          if (wr_cmd && cont_ok) begin
            desc_req_q <= 1'b1;
            cur_q      <= sptr_q;
            ct_q       <= CT_RELOAD;
          end
        end
        CT_RELOAD: begin
          if (desc_ack_i) begin
            if (!desc_eol_i && eol_q) begin
              sptr_q     <= desc_next_i;
              cur_q      <= desc_next_i;
              desc_req_q <= 1'b1;
              ct_q       <= CT_FOLLOW;
            end else begin
              ct_q <= CT_IDLE;
            end
          end
        end
        CT_FOLLOW: begin
          if (desc_ack_i && !wr_cfg) begin
            start_q <= 1'b1;
            state_q <= ST_RUN;
            eol_q   <= 1'b0;
            ct_q    <= CT_IDLE;
          end
        end
        default: ct_q <= CT_IDLE;
      endcase

      // config write overrides state and aborts a pending continue
      if (wr_cfg) begin
        cfg_q <= wdata_i;
        ct_q  <= CT_IDLE;
        if (!wdata_i[0])     state_q <= ST_RST;
        else if (wdata_i[1]) state_q <= ST_STOP;
      end
    end
  end

  always_comb begin
    unique case (idx_i)
      IX_CUR:  rdata_o = cur_q;
      IX_SPTR: rdata_o = sptr_q;
      IX_SBUF: rdata_o = sbuf_q;
      IX_GRP:  rdata_o = grp_q;
      IX_GDN:  rdata_o = gdn_q;
      IX_CMD:  rdata_o = cmd_q;
      IX_CFG:  rdata_o = cfg_q;
      IX_STAT: rdata_o = {22'd0, STREAM_SRC, 2'd0, eol_q, 2'd0, state_q};
      IX_MASK: rdata_o = 32'(mask_w);
      IX_RAW:  rdata_o = 32'(raw_w);
      IX_MSKD: rdata_o = 32'(raw_w & mask_w);
      IX_STRM: rdata_o = strm_q;
      default: rdata_o = '0;
    endcase
  end

  assign desc_req_o  = desc_req_q;
  assign desc_addr_o = cur_q;
  assign ctx_req_o   = ctx_req_q;
  assign ctx_addr_o  = gdn_q;
  assign start_o     = start_q;

  AST_CFG_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cfg && !wdata_i[0]) |=> (state_q == ST_RST)); // R3
  AST_CFG_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cfg && (wdata_i[1:0] == 2'b11)) |=> (state_q == ST_STOP)); // R3
  AST_START_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> ((state_q == ST_RUN) && !eol_q)); // R6
  AST_CONT_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && (ct_q == CT_IDLE) &&
     !(cfg_q[0] && !cfg_q[1] && (state_q == ST_RUN) && cur_eol_q))
    |=> !desc_req_o); // R8
  AST_EOL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eol_hit_i && !ld_d && (ct_q != CT_FOLLOW)) |=> eol_q); // R10
endmodule

// File: rtl/dmach_regif.sv
module dmach_regif
  import dmach_pkg::*;
#(
  parameter  int NUM_CH  = 2,
  parameter  int CAUSE_W = 4,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W  = WIN_LSB + CH_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [3:0]                be_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  output logic                      err_o,
  input  logic [NUM_CH*CAUSE_W-1:0] cause_i,
  input  logic [NUM_CH-1:0]         desc_ack_i,
  input  logic [NUM_CH-1:0]         desc_eol_i,
  input  logic [NUM_CH*32-1:0]      desc_next_i,
  input  logic [NUM_CH-1:0]         eol_hit_i,
  output logic [NUM_CH-1:0]         desc_req_o,
  output logic [NUM_CH*32-1:0]      desc_addr_o,
  output logic [NUM_CH-1:0]         ctx_req_o,
  output logic [NUM_CH*32-1:0]      ctx_addr_o,
  output logic [NUM_CH-1:0]         start_o,
  output logic [NUM_CH-1:0]         irq_o
);
  logic [CH_W-1:0]   ch;
  logic [5:0]        idx;
  logic [NUM_CH-1:0] wr_vec;
  logic              rd_ok, err_c;
  logic [31:0]       chan_rd [NUM_CH];
  logic [31:0]       rdata_q;
  logic              err_q;

  dmach_dec #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
    .req_i   (req_i),
    .we_i    (we_i),
    .be_i    (be_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .ch_o    (ch),
    .idx_o   (idx),
    .wr_o    (wr_vec),
    .rd_o    (rd_ok),
    .err_o   (err_c)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dmach_chan #(.CAUSE_W(CAUSE_W)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (wr_vec[i]),
      .idx_i       (idx),
      .wdata_i     (wdata_i),
      .cause_i     (cause_i[i*CAUSE_W +: CAUSE_W]),
      .desc_ack_i  (desc_ack_i[i]),
      .desc_eol_i  (desc_eol_i[i]),
      .desc_next_i (desc_next_i[i*32 +: 32]),
      .eol_hit_i   (eol_hit_i[i]),
      .rdata_o     (chan_rd[i]),
      .desc_req_o  (desc_req_o[i]),
      .desc_addr_o (desc_addr_o[i*32 +: 32]),
      .ctx_req_o   (ctx_req_o[i]),
      .ctx_addr_o  (ctx_addr_o[i*32 +: 32]),
      .start_o     (start_o[i]),
      .irq_o       (irq_o[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= err_c;
      if (req_i && !we_i) rdata_q <= rd_ok ? chan_rd[ch] : '0;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  AST_ERR_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (be_i != 4'hF)) |=> err_o); // R11
  AST_ERR_BADRD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (be_i != 4'hF)) |=> (rdata_o == '0)); // R11
endmodule

// File: tb/dmach_regif_test.sv
module dmach_regif_test;
  localparam int NCH = 2;
  localparam int CW  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [3:0]    be = 4'hF;
  logic [13:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          err;
  logic [NCH*CW-1:0] cause = '0;
  logic [NCH-1:0]    dack = '0, deol = '0, hit = '0;
  logic [NCH*32-1:0] dnext = '0;
  logic [NCH-1:0]    dreq, creq, start, irq;
  logic [NCH*32-1:0] daddr, caddr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] c_rdata;
  logic        c_err;
  logic [1:0]  c_dreq, c_creq, c_start, c_irq;
  logic [31:0] c_daddr, c_caddr;

  always #5 clk = ~clk;

  dmach_regif #(.NUM_CH(NCH), .CAUSE_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .be_i(be),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .cause_i(cause), .desc_ack_i(dack), .desc_eol_i(deol),
    .desc_next_i(dnext), .eol_hit_i(hit), .desc_req_o(dreq),
    .desc_addr_o(daddr), .ctx_req_o(creq), .ctx_addr_o(caddr),
    .start_o(start), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one clock with current stimulus; capture just after the edge, then clear
  task automatic step();
    @(posedge clk);
    #1;
    c_rdata = rdata; c_err = err; c_dreq = dreq; c_creq = creq;
    c_start = start; c_irq = irq; c_daddr = daddr[31:0]; c_caddr = caddr[31:0];
    req = 0; we = 0; be = 4'hF; cause = '0; dack = '0; deol = '0; hit = '0; dnext = '0;
  endtask

  task automatic bus(input logic w, input logic [3:0] b, input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = w; be = b; addr = a; wdata = d;
    step();
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    bus(1'b1, 4'hF, a, d);
  endtask

  task automatic rd(input logic [13:0] a);
    bus(1'b0, 4'hF, a, 32'h0);
  endtask

  task automatic ack0(input logic e, input logic [31:0] nxt);
    @(negedge clk);
    dack[0] = 1; deol[0] = e; dnext[31:0] = nxt;
    step();
  endtask

  task automatic cause0(input logic [3:0] v);
    @(negedge clk);
    cause[3:0] = v;
    step();
  endtask

  // waddr, wdata, raddr, expected read
  localparam logic [91:0] TBL [15] = '{
    {14'h0058, 32'h1234_5678, 14'h0058, 32'h1234_5678},  // R1
    {14'h005C, 32'hA5A5_0004, 14'h005C, 32'hA5A5_0004},  // R1
    {14'h0060, 32'h0000_1F00, 14'h0060, 32'h0000_1F00},  // R1
    {14'h007C, 32'hCAFE_0010, 14'h007C, 32'hCAFE_0010},  // R1
    {14'h0000, 32'h0000_0200, 14'h0000, 32'h0000_0200},  // R1
    {14'h2058, 32'hDEAD_BEEF, 14'h0058, 32'h1234_5678},  // R1 channel isolation
    {14'h205C, 32'h0000_0001, 14'h2058, 32'hDEAD_BEEF},  // R1
    {14'h0040, 32'hFFFF_FFFF, 14'h0040, 32'h0000_0000},  // R1 unmapped
    {14'h008C, 32'h0000_000F, 14'h008C, 32'h0000_000F},  // R4 mask
    {14'h0090, 32'h0000_000F, 14'h0090, 32'h0000_0000},  // R5 ack reads 0
    {14'h0088, 32'hFFFF_FFFF, 14'h0088, 32'h0000_0101},  // R3 status read-only
    {14'h0084, 32'h0000_0003, 14'h0088, 32'h0000_0102},  // R3 stopped
    {14'h0084, 32'h0000_0002, 14'h0088, 32'h0000_0101},  // R3 reset wins
    {14'h0084, 32'h0000_0001, 14'h0088, 32'h0000_0101},  // R3 unchanged
    {14'h0084, 32'h0000_0001, 14'h0084, 32'h0000_0001}   // R1 config readback
  };

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R2 reset state
    rd(14'h0088); chk("R2 status ch0", c_rdata, 32'h101);
    rd(14'h2088); chk("R2 status ch1", c_rdata, 32'h101);
    rd(14'h0058); chk("R2 sptr", c_rdata, 0);
    chk("R2 irq", {30'd0, c_irq}, 0);
    chk("R2 strobes", {26'd0, c_dreq, c_creq, c_start}, 0);

    for (int i = 0; i < 15; i++) begin
      wr(TBL[i][91:78], TBL[i][77:46]);
      rd(TBL[i][45:32]);
      chk($sformatf("TBL[%0d]", i), c_rdata, TBL[i][31:0]);
    end

    // R4 interrupt merge
    wr(14'h008C, 32'h4);
    cause0(4'h1); chk("R4 masked-off irq", {31'd0, c_irq[0]}, 0);
    rd(14'h0094); chk("R4 raw", c_rdata, 32'h1);
    cause0(4'h4); chk("R4 irq high", {31'd0, c_irq[0]}, 1);
    chk("R4 ch1 irq low", {31'd0, c_irq[1]}, 0);
    rd(14'h0098); chk("R4 masked", c_rdata, 32'h4);
    wr(14'h008C, 32'h0); chk("R4 mask clears irq", {31'd0, c_irq[0]}, 0);
    wr(14'h008C, 32'hF); chk("R4 mask sets irq", {31'd0, c_irq[0]}, 1);
    // R5 acknowledge
    wr(14'h0090, 32'h1);
    rd(14'h0094); chk("R5 ack bit0", c_rdata, 32'h4);
    @(negedge clk); cause[3:0] = 4'h4; req = 1; we = 1; be = 4'hF; addr = 14'h0090; wdata = 32'h4; step();
    rd(14'h0094); chk("R5 cause wins", c_rdata, 32'h4);
    wr(14'h0090, 32'h4); chk("R5 irq drops", {31'd0, c_irq[0]}, 0);
    rd(14'h0094); chk("R5 raw cleared", c_rdata, 32'h0);

    // R6 stream loads
    wr(14'h0058, 32'h0000_3000);
    wr(14'h009C, 32'h140);
    chk("R6 dreq", {31'd0, c_dreq[0]}, 1); chk("R6 daddr", c_daddr, 32'h3000);
    chk("R6 no start", {31'd0, c_start[0]}, 0);
    rd(14'h0000); chk("R6 cur reg", c_rdata, 32'h3000);
    rd(14'h0088); chk("R6 state unchanged", c_rdata, 32'h101);
    wr(14'h009C, 32'h160);
    chk("R6 burst dreq", {31'd0, c_dreq[0]}, 1); chk("R6 burst start", {31'd0, c_start[0]}, 1);
    rd(14'h0088); chk("R6 running", c_rdata, 32'h104);
    wr(14'h009C, 32'h040); chk("R6 overlap 0x40", {31'd0, c_dreq[0]}, 1);
    wr(14'h009C, 32'h100); chk("R6 overlap 0x100", {31'd0, c_dreq[0]}, 1);
    wr(14'h009C, 32'h020); chk("R6 burst alone", {30'd0, c_dreq[0], c_start[0]}, 0);
    // R7 context load
    wr(14'h007C, 32'h0000_4400);
    wr(14'h009C, 32'h200);
    chk("R7 creq", {31'd0, c_creq[0]}, 1); chk("R7 caddr", c_caddr, 32'h4400);
    chk("R7 no dreq", {31'd0, c_dreq[0]}, 0);
    // R12 value flags
    wr(14'h009C, 32'h400);
    chk("R12 strm err", {31'd0, c_err}, 1); chk("R12 no load", {31'd0, c_dreq[0]}, 0);
    rd(14'h009C); chk("R12 strm written", c_rdata, 32'h400);
    wr(14'h0080, 32'h2); chk("R12 cmd err", {31'd0, c_err}, 1);
    rd(14'h0080); chk("R12 cmd written", c_rdata, 32'h2);
    // R11 partial access
    bus(1'b1, 4'h3, 14'h0058, 32'hFFFF_FFFF); chk("R11 wr err", {31'd0, c_err}, 1);
    rd(14'h0058); chk("R11 no change", c_rdata, 32'h3000);
    chk("R11 err single", {31'd0, c_err}, 0);
    bus(1'b0, 4'h1, 14'h0058, 32'h0);
    chk("R11 rd err", {31'd0, c_err}, 1); chk("R11 rd zero", c_rdata, 0);

    // R10 end-of-list notice
    @(negedge clk); hit[0] = 1; step();
    rd(14'h0088); chk("R10 eol flag", c_rdata, 32'h124);

    // R8 gating
    ack0(1'b1, 32'h0);
    wr(14'h0084, 32'h3);
    wr(14'h0080, 32'h1); chk("R8 stopped blocks", {31'd0, c_dreq[0]}, 0);
    wr(14'h0084, 32'h1);
    rd(14'h0088); chk("R3 stays stopped", c_rdata, 32'h122);
    wr(14'h0080, 32'h1); chk("R8 not running blocks", {31'd0, c_dreq[0]}, 0);
    wr(14'h009C, 32'h160); chk("R6 restart", {31'd0, c_start[0]}, 1);
    ack0(1'b1, 32'h0);
    @(negedge clk); hit[0] = 1; step();

    // R9 continue follows next pointer
    wr(14'h0080, 32'h1);
    chk("R9 reload req", {31'd0, c_dreq[0]}, 1); chk("R9 reload addr", c_daddr, 32'h3000);
    ack0(1'b0, 32'h5000);
    chk("R9 follow req", {31'd0, c_dreq[0]}, 1); chk("R9 follow addr", c_daddr, 32'h5000);
    ack0(1'b0, 32'h0);
    chk("R9 start", {31'd0, c_start[0]}, 1);
    rd(14'h0088); chk("R9 running eol clear", c_rdata, 32'h104);
    rd(14'h0058); chk("R9 sptr next", c_rdata, 32'h5000);
    wr(14'h0080, 32'h1); chk("R8 desc eol clear blocks", {31'd0, c_dreq[0]}, 0);
    // R9 no follow when channel flag is clear
    ack0(1'b1, 32'h0);
    wr(14'h0080, 32'h1);
    chk("R9 reload2", {31'd0, c_dreq[0]}, 1); chk("R9 reload2 addr", c_daddr, 32'h5000);
    ack0(1'b0, 32'h6000);
    chk("R9 no follow", {30'd0, c_dreq[0], c_start[0]}, 0);
    rd(14'h0058); chk("R9 sptr kept", c_rdata, 32'h5000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule